// File: doc/BRIEF.md
# Memory Bank Configuration Register Port

This block is the byte-wide I/O register front end of a memory controller with six module sockets. It takes a static strap per socket that says whether the socket is empty, holds a small module or holds a large module. Through a small set of I/O offsets it lets software find out which sockets are populated and which of them carry large modules. It also offers a fixed parity status byte.

Software programs the bank layout by writing an eight-entry table of 5-bit bank end addresses. Each write is a packed byte: the upper three bits name the entry and the lower five bits carry the value. Readback has no index in the data. A hidden pointer walks the table one entry per read and wraps after the last entry. Software rewinds that pointer by reading the presence register. The whole table is also driven out in parallel so that a neighbouring bank decoder can use it.

Reads are registered. A read strobe is acted on once, in the clock cycle where it is first seen high. The returned byte appears on the read data output after that clock edge and stays there until the next read strobe rises.

Top module: `membank_cfg_port`

## Requirements
- R1: While reset is asserted and right after it is released, every table entry, the readback pointer and the read data output are all 0.
- R2: A read of offset 0x803 returns a byte where bit n (n = 0..5) is 1 only if socket n's strap is 2'b10 (large). Bits 6 and 7 read 0. Socket n's strap is socket_size_i[2n+1:2n]: 2'b00 is empty, 2'b01 is small, 2'b10 is large, and 2'b11 is populated but not large.
- R3: A read of offset 0x804 returns an active-low presence byte. Bit n is 0 if socket n's strap is anything other than 2'b00, and bits 6 and 7 always read 1.
- R4: A write to offset 0x820 stores wr_data_i[4:0] into the table entry selected by wr_data_i[7:5]. The new value shows on end_addr_o[5e+4:5e] for entry e from the next clock on.
- R5: A read of offset 0x820 returns the entry at the readback pointer in bits [4:0], with bits [7:5] at 0. The pointer then advances by one and wraps from 7 to 0.
- R6: Any read of offset 0x804 sets the readback pointer back to 0.
- R7: A read of offset 0x841 always returns 0x01.
- R8: Each rising edge of rd_i acts exactly once, however long the strobe is held. rd_data_o takes the result at the first clock where rd_i is high and keeps it until the next rising edge of rd_i.
- R9: A read of any other offset returns 0x00. A write to any offset other than 0x820 leaves the table unchanged.
- R10: When a write and a read to 0x820 happen in the same cycle, the write is stored first. The read returns the entry at the pointer before it advances, including the newly written value if the write targets that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| socket_size_i | input | 12 | Per-socket module strap, 2 bits per socket |
| addr_i | input | 12 | I/O offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data: entry index in [7:5], end address in [4:0] |
| rd_data_o | output | 8 | Registered read data |
| end_addr_o | output | 40 | Flattened end-address table, 5 bits per entry |

## Verification
The bench walks the readback pointer past the last entry. A design that did not wrap would return stale or zero data on the ninth read. The bench also rewinds the pointer through a presence read partway through a walk; a design without the rewind keeps reading from the middle of the table. It holds a read strobe for several cycles, which exposes a design that advances the pointer on every cycle of the strobe: that design skips entries. It issues a same-cycle write and read to the table entry under the pointer. A design that reads before it writes returns the old value there. Finally it sends writes to a neighbouring unmapped offset and uses strap code 2'b11. These catch a loose address decode, and a design that treats 2'b11 as large.

// File: rtl/membank_pkg.sv
package membank_pkg;

   // per-socket strap coding
   typedef enum logic [1:0] {
      MOD_NONE  = 2'b00,
      MOD_SMALL = 2'b01,
      MOD_LARGE = 2'b10,
      MOD_RSVD  = 2'b11
   } mod_size_e;

   // decoded register selection
   typedef enum logic [2:0] {
      SEL_NONE   = 3'd0,
      SEL_ID     = 3'd1,
      SEL_PRES   = 3'd2,
      SEL_SIZE   = 3'd3,
      SEL_PARITY = 3'd4
   } reg_sel_e;

endpackage

// File: rtl/membank_status.sv
module membank_status
   import membank_pkg::*;
#(
   parameter int NUM_SOCKETS = 6,
   parameter int DATA_W      = 8
) (
   input  logic [2*NUM_SOCKETS-1:0] socket_size_i,
   output logic [DATA_W-1:0]        large_map_o,
   output logic [DATA_W-1:0]        present_n_o
);

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      if (g < NUM_SOCKETS) begin : g_sock
         assign large_map_o[g] = (socket_size_i[2*g +: 2] == MOD_LARGE);
         assign present_n_o[g] = (socket_size_i[2*g +: 2] == MOD_NONE);
      end else begin : g_pad
         assign large_map_o[g] = 1'b0;
         assign present_n_o[g] = 1'b1;
      end
   end

endmodule

// File: rtl/membank_addr_dec.sv
module membank_addr_dec
   import membank_pkg::*;
#(
   parameter int              ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] OFS_ID     = 12'h803,
   parameter logic [ADDR_W-1:0] OFS_PRES   = 12'h804,
   parameter logic [ADDR_W-1:0] OFS_SIZE   = 12'h820,
   parameter logic [ADDR_W-1:0] OFS_PARITY = 12'h841
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);

   always_comb begin
      if (addr_i == OFS_ID)          sel_o = SEL_ID;
      else if (addr_i == OFS_PRES)   sel_o = SEL_PRES;
      else if (addr_i == OFS_SIZE)   sel_o = SEL_SIZE;
      else if (addr_i == OFS_PARITY) sel_o = SEL_PARITY;
      else                           sel_o = SEL_NONE;
   end

endmodule

// File: rtl/membank_end_table.sv
module membank_end_table #(
   parameter int NUM_ENTRIES = 8,
   parameter int END_W       = 5,
   parameter bit WRITE_FIRST = 1'b1,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         wr_en_i,
   input  logic [IDX_W-1:0]             wr_sel_i,
   input  logic [END_W-1:0]             wr_val_i,
   input  logic                         adv_i,
   input  logic                         clr_i,
   output logic [END_W-1:0]             rd_val_o,
   output logic [NUM_ENTRIES*END_W-1:0] end_flat_o
);

   logic [NUM_ENTRIES-1:0][END_W-1:0] ent_q;
   logic [IDX_W-1:0]                  idx_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ent_q <= '0;
      end else if (wr_en_i) begin
         for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (wr_sel_i == IDX_W'(e)) ent_q[e] <= wr_val_i;
         end
      end
   end

   // pointer: rewind has priority, power-of-two depth wraps naturally
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     idx_q <= '0;
      else if (clr_i)  idx_q <= '0;
      else if (adv_i)  idx_q <= idx_q + 1'b1;
   end

   if (WRITE_FIRST) begin : g_fwd
      assign rd_val_o = (wr_en_i && (wr_sel_i == idx_q)) ? wr_val_i : ent_q[idx_q];
   end else begin : g_nofwd
      assign rd_val_o = ent_q[idx_q];
   end

   assign end_flat_o = ent_q;

endmodule

// File: rtl/membank_cfg_port.sv
module membank_cfg_port
   import membank_pkg::*;
#(
   parameter int                NUM_SOCKETS = 6,
   parameter int                NUM_ENTRIES = 8,
   parameter int                ADDR_W      = 12,
   parameter int                DATA_W      = 8,
   parameter int                END_W       = 5,
   parameter bit                WRITE_FIRST = 1'b1,
   parameter logic [ADDR_W-1:0] OFS_ID      = 12'h803,
   parameter logic [ADDR_W-1:0] OFS_PRES    = 12'h804,
   parameter logic [ADDR_W-1:0] OFS_SIZE    = 12'h820,
   parameter logic [ADDR_W-1:0] OFS_PARITY  = 12'h841,
   parameter logic [DATA_W-1:0] PARITY_OK   = 8'h01
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic [2*NUM_SOCKETS-1:0]     socket_size_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic                         rd_i,
   input  logic                         wr_i,
   input  logic [DATA_W-1:0]            wr_data_i,
   output logic [DATA_W-1:0]            rd_data_o,
   output logic [NUM_ENTRIES*END_W-1:0] end_addr_o
);

   localparam int IDX_W = $clog2(NUM_ENTRIES);

   if (IDX_W + END_W != DATA_W) begin : g_chk_pack
      $error("entry index plus end address must fill the data byte");
   end
   if ((1 << IDX_W) != NUM_ENTRIES) begin : g_chk_pow2
      $error("table depth must be a power of two");
   end
   if (NUM_SOCKETS > DATA_W) begin : g_chk_sock
      $error("socket count exceeds data width");
   end

   reg_sel_e            sel;
   logic [DATA_W-1:0]   large_map, present_n, rd_next, rd_data_q;
   logic [END_W-1:0]    tbl_rd_val;
   logic                rd_q, rd_rise, tbl_wr;

   membank_addr_dec #(
      .ADDR_W(ADDR_W), .OFS_ID(OFS_ID), .OFS_PRES(OFS_PRES),
      .OFS_SIZE(OFS_SIZE), .OFS_PARITY(OFS_PARITY)
   ) u_dec (
      .addr_i (addr_i),
      .sel_o  (sel)
   );

   membank_status #(.NUM_SOCKETS(NUM_SOCKETS), .DATA_W(DATA_W)) u_status (
      .socket_size_i (socket_size_i),
      .large_map_o   (large_map),
      .present_n_o   (present_n)
   );

   assign rd_rise = rd_i && !rd_q;
   assign tbl_wr  = wr_i && (sel == SEL_SIZE);

   membank_end_table #(
      .NUM_ENTRIES(NUM_ENTRIES), .END_W(END_W), .WRITE_FIRST(WRITE_FIRST)
   ) u_table (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (tbl_wr),
      .wr_sel_i   (wr_data_i[DATA_W-1 -: IDX_W]),
      .wr_val_i   (wr_data_i[END_W-1:0]),
      .adv_i      (rd_rise && (sel == SEL_SIZE)),
      .clr_i      (rd_rise && (sel == SEL_PRES)),
      .rd_val_o   (tbl_rd_val),
      .end_flat_o (end_addr_o)
   );

   always_comb begin
      case (sel)
         SEL_ID:     rd_next = large_map;
         SEL_PRES:   rd_next = present_n;
         SEL_SIZE:   rd_next = {{(DATA_W-END_W){1'b0}}, tbl_rd_val};
         SEL_PARITY: rd_next = PARITY_OK;
         default:    rd_next = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_q      <= 1'b0;
         rd_data_q <= '0;
      end else begin
         rd_q <= rd_i;
         if (rd_rise) rd_data_q <= rd_next;
      end
   end

   assign rd_data_o = rd_data_q;

endmodule

// File: rtl/membank_cfg_port_chk.sv
module membank_cfg_port_chk #(
   parameter int                NUM_SOCKETS = 6,
   parameter int                NUM_ENTRIES = 8,
   parameter int                ADDR_W      = 12,
   parameter int                DATA_W      = 8,
   parameter int                END_W       = 5,
   parameter logic [ADDR_W-1:0] OFS_ID      = 12'h803,
   parameter logic [ADDR_W-1:0] OFS_PRES    = 12'h804,
   parameter logic [ADDR_W-1:0] OFS_SIZE    = 12'h820,
   parameter logic [ADDR_W-1:0] OFS_PARITY  = 12'h841,
   parameter logic [DATA_W-1:0] PARITY_OK   = 8'h01
) (
   input logic                         clk_i,
   input logic                         rst_ni,
   input logic [2*NUM_SOCKETS-1:0]     socket_size_i,
   input logic [ADDR_W-1:0]            addr_i,
   input logic                         rd_i,
   input logic                         wr_i,
   input logic [DATA_W-1:0]            wr_data_i,
   input logic [DATA_W-1:0]            rd_data_o,
   input logic [NUM_ENTRIES*END_W-1:0] end_addr_o
);

   localparam int IDX_W = $clog2(NUM_ENTRIES);

   logic                    rd_prev, wr_q;
   logic [IDX_W-1:0]        wsel_q;
   logic [END_W-1:0]        wval_q;
   logic [2*NUM_SOCKETS-1:0] strap_q;
   logic                    rise, mapped;

   assign rise   = rd_i && !rd_prev;
   assign mapped = (addr_i == OFS_ID) || (addr_i == OFS_PRES) ||
                   (addr_i == OFS_SIZE) || (addr_i == OFS_PARITY);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_prev <= 1'b0;
         wr_q    <= 1'b0;
         wsel_q  <= '0;
         wval_q  <= '0;
         strap_q <= '0;
      end else begin
         rd_prev <= rd_i;
         wr_q    <= wr_i && (addr_i == OFS_SIZE);
         wsel_q  <= wr_data_i[DATA_W-1 -: IDX_W];
         wval_q  <= wr_data_i[END_W-1:0];
         strap_q <= socket_size_i;
      end
   end

   function automatic logic [NUM_SOCKETS-1:0] pres_bits(input logic [2*NUM_SOCKETS-1:0] s);
      for (int k = 0; k < NUM_SOCKETS; k++) pres_bits[k] = (s[2*k +: 2] == 2'b00);
   endfunction

   // R4
   table_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_q |-> end_addr_o[int'(wsel_q)*END_W +: END_W] == wval_q);

   // R2
   id_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise && addr_i == OFS_ID) |=> rd_data_o[DATA_W-1:NUM_SOCKETS] == '0);

   // R3
   presence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise && addr_i == OFS_PRES) |=>
         (rd_data_o[DATA_W-1:NUM_SOCKETS] == '1 &&
          rd_data_o[NUM_SOCKETS-1:0] == pres_bits(strap_q)));

   // R5
   size_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise && addr_i == OFS_SIZE) |=> rd_data_o[DATA_W-1:END_W] == '0);

   // R7
   parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise && addr_i == OFS_PARITY) |=> rd_data_o == PARITY_OK);

   // R8
   held_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && rd_prev) |=> $stable(rd_data_o));

   // R9
   unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise && !mapped) |=> rd_data_o == '0);

   // R9
   unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i != OFS_SIZE) |=> $stable(end_addr_o));

endmodule

bind membank_cfg_port membank_cfg_port_chk #(
   .NUM_SOCKETS(NUM_SOCKETS), .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .END_W(END_W), .OFS_ID(OFS_ID), .OFS_PRES(OFS_PRES),
   .OFS_SIZE(OFS_SIZE), .OFS_PARITY(OFS_PARITY), .PARITY_OK(PARITY_OK)
) u_chk (.*);

// File: tb/membank_cfg_port_test.sv
module membank_cfg_port_test;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [11:0] socket_size_i = '0;
   logic [11:0] addr_i = '0;
   logic        rd_i = 1'b0;
   logic        wr_i = 1'b0;
   logic [7:0]  wr_data_i = '0;
   logic [7:0]  rd_data_o;
   logic [39:0] end_addr_o;

   membank_cfg_port uut (.*);

   always #10 clk_i = ~clk_i;

   int    n_run = 0, n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural reference model
   int tbl[8];
   int idx = 0;
   int exp_rd = 0;
   bit prev_rd = 1'b0;

   function automatic int id_val(input logic [11:0] s);
      int v = 0;
      for (int k = 0; k < 6; k++) if (s[2*k +: 2] == 2'b10) v += (1 << k);
      return v;
   endfunction

   function automatic int pres_val(input logic [11:0] s);
      int v = 255;
      for (int k = 0; k < 6; k++) if (s[2*k +: 2] != 2'b00) v -= (1 << k);
      return v;
   endfunction

   always @(posedge clk_i) begin
      if (!rst_ni) begin
         foreach (tbl[e]) tbl[e] = 0;
         idx = 0; exp_rd = 0; prev_rd = 1'b0;
      end else begin
         bit rise;
         rise = rd_i && !prev_rd;
         if (wr_i && addr_i == 12'h820) tbl[wr_data_i[7:5]] = int'(wr_data_i[4:0]);
         if (rise) begin
            case (addr_i)
               12'h803: exp_rd = id_val(socket_size_i);
               12'h804: begin exp_rd = pres_val(socket_size_i); idx = 0; end
               12'h820: begin exp_rd = tbl[idx]; idx = (idx + 1) % 8; end
               12'h841: exp_rd = 1;
               default: exp_rd = 0;
            endcase
         end
         prev_rd = rd_i;
      end
   end

   always @(negedge clk_i) begin
      if (rst_ni && !done) begin
         n_run++;
         if (int'(rd_data_o) != exp_rd) begin
            n_fail++;
            $display("FAIL %s: rd_data_o actual %0h expected %0h", cur_req, rd_data_o, exp_rd);
         end
         for (int e = 0; e < 8; e++) begin
            if (int'(end_addr_o[e*5 +: 5]) != tbl[e]) begin
               n_fail++;
               $display("FAIL %s: entry %0d actual %0h expected %0h",
                        cur_req, e, end_addr_o[e*5 +: 5], tbl[e]);
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // single read pulse; returns data visible after the capturing edge
   task automatic rd_op(input logic [11:0] a, input int hold, output int d);
      @(negedge clk_i);
      addr_i = a; rd_i = 1'b1;
      repeat (hold) @(negedge clk_i);
      d = int'(rd_data_o);
      rd_i = 1'b0;
   endtask

   task automatic wr_op(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk_i);
      addr_i = a; wr_i = 1'b1; wr_data_i = d;
      @(negedge clk_i);
      wr_i = 1'b0;
   endtask

   task automatic finish_up;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk_i);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      int d;
      repeat (3) @(negedge clk_i);
      // R1: reset state
      check("R1", int'(rd_data_o), 0);
      check("R1", int'(end_addr_o), 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check("R1", int'(end_addr_o), 0);
      rd_op(12'h820, 1, d);
      check("R1", d, 0);

      // R2 / R3 with a mixed strap: s0,s1 large, s2,s3 small, s4,s5 empty
      cur_req = "R2";
      socket_size_i = {2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10};
      rd_op(12'h803, 1, d); check("R2", d, 8'h03);
      cur_req = "R3";
      rd_op(12'h804, 1, d); check("R3", d, 8'hF0);
      // all large
      socket_size_i = {6{2'b10}};
      cur_req = "R2";
      rd_op(12'h803, 1, d); check("R2", d, 8'h3F);
      cur_req = "R3";
      rd_op(12'h804, 1, d); check("R3", d, 8'hC0);
      // code 2'b11 is populated but not large; all empty
      socket_size_i = {2'b11, 10'b0};
      cur_req = "R2";
      rd_op(12'h803, 1, d); check("R2", d, 8'h00);
      cur_req = "R3";
      rd_op(12'h804, 1, d); check("R3", d, 8'hDF);

      // R4: fill the table, entry e gets 3*e+1
      cur_req = "R4";
      for (int e = 0; e < 8; e++) wr_op(12'h820, {3'(e), 5'(3*e + 1)});
      check("R4", int'(end_addr_o[7*5 +: 5]), 22);
      check("R4", int'(end_addr_o[2*5 +: 5]), 7);

      // R5: walk and wrap
      cur_req = "R5";
      rd_op(12'h804, 1, d);
      for (int e = 0; e < 8; e++) begin
         rd_op(12'h820, 1, d); check("R5", d, 3*e + 1);
      end
      rd_op(12'h820, 1, d); check("R5", d, 1);

      // R6: rewind mid-walk
      cur_req = "R6";
      rd_op(12'h820, 1, d);
      rd_op(12'h804, 1, d);
      rd_op(12'h820, 1, d); check("R6", d, 1);

      // R7
      cur_req = "R7";
      rd_op(12'h841, 1, d); check("R7", d, 1);

      // R8: held strobe advances once
      cur_req = "R8";
      rd_op(12'h820, 4, d); check("R8", d, 4);
      rd_op(12'h820, 1, d); check("R8", d, 7);

      // R9: unmapped offsets
      cur_req = "R9";
      rd_op(12'h805, 1, d); check("R9", d, 0);
      wr_op(12'h821, 8'h1F);
      wr_op(12'h804, 8'h3F);
      check("R9", int'(end_addr_o[0 +: 5]), 1);
      check("R9", int'(end_addr_o[1*5 +: 5]), 4);

      // R10: write and read of the pointed entry in one cycle (pointer at 3)
      cur_req = "R10";
      @(negedge clk_i);
      addr_i = 12'h820; wr_i = 1'b1; wr_data_i = {3'd3, 5'd30}; rd_i = 1'b1;
      @(negedge clk_i);
      wr_i = 1'b0; rd_i = 1'b0;
      check("R10", int'(rd_data_o), 30);
      check("R10", int'(end_addr_o[3*5 +: 5]), 30);
      rd_op(12'h820, 1, d); check("R10", d, 13);

      repeat (2) @(negedge clk_i);
      finish_up();
   end

endmodule